// File: doc/BRIEF.md
# Triple-Redundant Counter with Self-Repairing Vote

This block holds a counter as three identical copies, each with its own state register and its own next-state logic. A bitwise two-of-three vote is taken on the register outputs, after the flip-flops. That voted value is the block's result. It is also the only value that any copy's next-state logic reads. A copy whose register has been disturbed therefore computes its next value from the agreed state, and it is back in step with the other two after the next clock edge. No separate repair sequence is needed.

The voted state is registered once more before it leaves the block. A three-bit flag vector reports, one cycle late, which copy disagreed with the vote. A test port lets a bench or a built-in self-test flip one chosen bit of one chosen copy's register on a chosen clock edge. This shows that the vote masks the upset and that the copy recovers. A parameter chooses between one shared voter and a private voter for each copy's feedback path.

Top module: `tmr_sync_counter`

## Requirements
- R1: While `rst` is high at a rising edge, all three copies, `q_out` and `copy_mismatch` load their reset values: the copies and `q_out` take INIT_VALUE (default 0), and `copy_mismatch` clears to 0.
- R2: At each rising edge with `en` high, the voted state advances by one, modulo 2^WIDTH. `q_out` shows the voted state one clock after it is formed, so `q_out` follows a reference counter delayed by one cycle.
- R3: Each output bit is the majority of the three copies' bits, (a&b)|(a&c)|(b&c). A corruption confined to one copy never changes `q_out`.
- R4: The next state of every copy is computed from the voted state. A copy corrupted at one edge equals the other two again after the following edge.
- R5: At each rising edge with `en` low, the voted state is held unchanged, and a corrupted copy still realigns to it.
- R6: At an edge with `inj_en` high, `rst` low and `inj_copy` equal to 0, 1 or 2, bit `inj_bit` of that copy's newly loaded value is inverted. Copy index 3 selects no copy and has no effect. Injection while `rst` is high has no effect.
- R7: `copy_mismatch[k]` (bit k refers to copy k) is high for exactly the one cycle that follows a cycle in which copy k differed from the vote. An injection at edge t therefore raises only that copy's bit, from edge t+1 to edge t+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, applied identically to all copies |
| inj_en | input | 1 | Fault-injection strobe for the current edge |
| inj_copy | input | 2 | Copy to disturb (0..2; 3 selects none) |
| inj_bit | input | BIT_IDX_W | Bit position to invert in the chosen copy |
| q_out | output | WIDTH | Registered voted counter value |
| copy_mismatch | output | 3 | Per-copy disagreement flags, one cycle late |

## Verification
From the ports, the hardest thing to reach is one copy being out of step while the others keep counting or holding. The observable evidence of that state is only a flag one cycle later and an output that must not move. The stimulus drives the injection port to sweep every copy against every bit position. It does so while counting, while the count is held, back to back across different copies on consecutive edges, and during reset. A long stretch of random upsets with random enables follows, and it carries the count across its wrap point. A behavioural counter in the bench predicts the output and the expected flag on every clock.

// File: rtl/tmr_ctr_pkg.sv
package tmr_ctr_pkg;
  localparam int unsigned NUM_COPIES = 3;
  typedef logic [1:0] copy_idx_t;
endpackage

// File: rtl/tmr_ctr_next.sv
module tmr_ctr_next #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             en,
  input  logic [WIDTH-1:0] voted_state,
  output logic [WIDTH-1:0] next_state
);
  // Next state is derived only from the voted value, never from the own register.
  always_comb begin
    if (en) next_state = voted_state + WIDTH'(1);
    else    next_state = voted_state;
  end
endmodule

// File: rtl/tmr_ctr_copy.sv
module tmr_ctr_copy #(
  parameter int unsigned    WIDTH      = 8,
  parameter logic [WIDTH-1:0] INIT_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] next_state,
  input  logic [WIDTH-1:0] flip_mask,
  output logic [WIDTH-1:0] state_q
);
  always_ff @(posedge clk) begin
    if (rst) state_q <= INIT_VALUE;
    else     state_q <= next_state ^ flip_mask;
  end

  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> state_q == INIT_VALUE);
endmodule

// File: rtl/tmr_ctr_vote.sv
module tmr_ctr_vote #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_c,
  output logic [WIDTH-1:0] voted
);
  always_comb voted = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);

  // Two agreeing inputs always decide the result.
  always_comb begin
    if (in_a == in_b) assert_pair_wins_R3: assert (voted == in_a);
    if (in_b == in_c) assert_pair_wins_bc_R3: assert (voted == in_b);
  end
endmodule

// File: rtl/tmr_sync_counter.sv
module tmr_sync_counter
  import tmr_ctr_pkg::*;
#(
  parameter int unsigned      WIDTH         = 8,
  parameter int unsigned      BIT_IDX_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  parameter logic [WIDTH-1:0] INIT_VALUE    = '0,
  parameter bit               SPLIT_VOTERS  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 inj_en,
  input  logic [1:0]           inj_copy,
  input  logic [BIT_IDX_W-1:0] inj_bit,
  output logic [WIDTH-1:0]     q_out,
  output logic [2:0]           copy_mismatch
);
  localparam logic [WIDTH-1:0] ONE_HOT_LSB = WIDTH'(1);

  logic [WIDTH-1:0] copy_q    [NUM_COPIES];
  logic [WIDTH-1:0] fb_vote   [NUM_COPIES];
  logic [WIDTH-1:0] copy_next [NUM_COPIES];
  logic [WIDTH-1:0] copy_flip [NUM_COPIES];
  logic [WIDTH-1:0] voted;
  logic [2:0]       differs;
  logic             inj_fire;

  assign inj_fire = inj_en && !rst && (inj_copy != copy_idx_t'(3));

  // Output voter, placed after the flip-flops.
  tmr_ctr_vote #(.WIDTH(WIDTH)) u_out_vote (
    .in_a (copy_q[0]),
    .in_b (copy_q[1]),
    .in_c (copy_q[2]),
    .voted(voted)
  );

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_copy
    if (SPLIT_VOTERS) begin : g_own_vote
      tmr_ctr_vote #(.WIDTH(WIDTH)) u_fb_vote (
        .in_a (copy_q[0]),
        .in_b (copy_q[1]),
        .in_c (copy_q[2]),
        .voted(fb_vote[k])
      );
    end else begin : g_shared_vote
      assign fb_vote[k] = voted;
    end

    assign copy_flip[k] = (inj_fire && inj_copy == copy_idx_t'(k))
                          ? (ONE_HOT_LSB << inj_bit) : '0;

    tmr_ctr_next #(.WIDTH(WIDTH)) u_next (
      .en         (en),
      .voted_state(fb_vote[k]),
      .next_state (copy_next[k])
    );

    tmr_ctr_copy #(.WIDTH(WIDTH), .INIT_VALUE(INIT_VALUE)) u_reg (
      .clk       (clk),
      .rst       (rst),
      .next_state(copy_next[k]),
      .flip_mask (copy_flip[k]),
      .state_q   (copy_q[k])
    );

    assign differs[k] = (copy_q[k] != voted);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out         <= INIT_VALUE;
      copy_mismatch <= '0;
    end else begin
      q_out         <= voted;
      copy_mismatch <= differs;
    end
  end

  // R3: a single upset leaves at most one copy out of line.
  assert_single_disagree_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(differs) <= 1);

  // R4: without an injection on the previous edge, all copies agree.
  assert_resync_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(inj_fire) |-> (copy_q[0] == copy_q[1] && copy_q[1] == copy_q[2]));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> voted == $past(voted) + WIDTH'(1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> voted == $past(voted));

  assert_flag_single_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(copy_mismatch));

  assert_ignored_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (inj_en && inj_copy == copy_idx_t'(3)) |=> differs == 3'b000);
endmodule

// File: tb/tmr_sync_counter_bench.sv
`timescale 1ns/1ps
module tmr_sync_counter_bench;
  localparam int WIDTH = 8;
  localparam int BIW   = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic             inj_en = 1'b0;
  logic [1:0]       inj_copy = 2'd0;
  logic [BIW-1:0]   inj_bit = '0;
  logic [WIDTH-1:0] q_out;
  logic [2:0]       copy_mismatch;

  always #2.5 clk = ~clk;

  tmr_sync_counter #(.WIDTH(WIDTH)) u_tmr_sync_counter (
    .clk(clk), .rst(rst), .en(en), .inj_en(inj_en), .inj_copy(inj_copy),
    .inj_bit(inj_bit), .q_out(q_out), .copy_mismatch(copy_mismatch)
  );

  int checks = 0;
  int fails  = 0;
  string phase_tag = "R1";
  bit done = 1'b0;

  // Behavioural reference: plain counter, delayed output, delayed flag.
  int unsigned m_state = 0;
  int unsigned m_out   = 0;
  int unsigned m_pend  = 0;
  int unsigned m_flag  = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_state <= 0; m_out <= 0; m_pend <= 0; m_flag <= 0;
    end else begin
      m_out   <= m_state;
      m_state <= en ? (m_state + 1) % 256 : m_state;
      m_flag  <= m_pend;
      m_pend  <= (inj_en && inj_copy != 2'd3) ? (1 << inj_copy) : 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      check(q_out == WIDTH'(m_out), phase_tag, int'(q_out), int'(m_out));
      check(copy_mismatch == 3'(m_flag), "R7", int'(copy_mismatch), int'(m_flag));
    end
  end

  task automatic step(input bit e, input bit ie, input int c, input int b);
    @(negedge clk);
    en = e; inj_en = ie; inj_copy = 2'(c); inj_bit = BIW'(b);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    // R1 and R6: injections during reset have no effect.
    phase_tag = "R1";
    step(1, 1, 0, 3); step(1, 1, 1, 7); step(0, 1, 2, 0);
    @(negedge clk);
    check(q_out == 8'd0, "R1", int'(q_out), 0);
    check(copy_mismatch == 3'b000, "R1", int'(copy_mismatch), 0);
    rst = 1'b0; inj_en = 1'b0; en = 1'b0;

    phase_tag = "R2";
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0);

    // R3/R4: every copy, every bit, while counting, spaced and back to back.
    phase_tag = "R3";
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < WIDTH; b++) begin
        step(1, 1, c, b); step(1, 0, 0, 0);
      end
    phase_tag = "R4";
    for (int i = 0; i < 12; i++) step(1, 1, i % 3, (i * 5) % WIDTH);

    // R5: hold with upsets.
    phase_tag = "R5";
    for (int i = 0; i < 12; i++) step(0, (i % 2) == 0, i % 3, i % WIDTH);
    step(0, 0, 0, 0); step(0, 0, 0, 0);

    // R6: copy index 3 selects nothing.
    phase_tag = "R6";
    for (int i = 0; i < 8; i++) step(i % 2, 1, 3, i);

    // Random upsets and enables, crossing the wrap point.
    phase_tag = "R2";
    for (int i = 0; i < 500; i++)
      step(($urandom % 4) != 0, ($urandom % 4) == 0, int'($urandom % 4), int'($urandom % WIDTH));

    // R1: mid-run reset.
    phase_tag = "R1";
    @(negedge clk); rst = 1'b1; en = 1'b1; inj_en = 1'b1; inj_copy = 2'd1;
    @(negedge clk); @(negedge clk);
    check(q_out == 8'd0, "R1", int'(q_out), 0);
    rst = 1'b0; inj_en = 1'b0;
    phase_tag = "R2";
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    @(posedge clk); #1;
    finish_run();
  end
endmodule